// File: doc/BRIEF.md
# IOMMU address range classifier

This block sits in front of an IOMMU's translation path and sorts every incoming device address into one of three routes. An address either passes straight through untranslated, goes on to the translation stage, or is rejected as a fault because it lies above the programmed address cap. The decision is combinational, so a bypassed address appears on the physical output in the same cycle it is presented.

Software programs four registers through a simple write/read port. The control register holds the unit enable, a global bypass, the three response enables and a sticky cap-fault flag. The cap register holds the cap limit. Two further registers describe a bypass window by its start and end. The window limits are counted in coarse units of 256 MB, or in fine units of 4 MB when the configuration input asks for them. The start limit is stored one below its boundary, so an address bypasses only above it. The end limit is stored as the boundary itself, and an address must lie below it. An invert control turns the window inside out, so that the addresses outside it bypass. This is how low memory is passed through unchanged while a translated aperture sits above it.

On a cap fault the block can abort the request in the same cycle. It can also raise an interrupt pulse, an exception pulse, or both, one cycle later. It always records the fault in the sticky flag.

Top module: `iommu_range_classifier`

## Requirements
- R1: After reset every register reads 0. The unit is disabled, so every address is routed as bypass (route code 2'b00).
- R2: While the enable bit (control bit 0) is 0, every address is routed as bypass with `phys_o` equal to `req_addr`. No abort is raised and the sticky flag is not set. Whenever an address is routed as bypass, `phys_o` equals `req_addr` in the same cycle; for other routes `phys_o` is 0.
- R3: With the unit enabled and the global bypass bit (control bit 8) set, every address is routed as bypass, including addresses above the cap.
- R4: The cap register has an enable in bit 31 and a limit in bits 7:0, counted in 256 MB units. When the cap is enabled, an address whose bits 35:28 exceed the limit is routed as fault (route code 2'b10), so the limit unit itself is still legal. The cap check takes priority over the bypass window. With the cap disabled, no address faults.
- R5: The start register holds an enable in bit 31 and a limit S in bits 13:0. The end register holds an enable in bit 31 and a limit E in bits 13:0. Let u be the address's unit index. A start bound holds when start is disabled or u > S. An end bound holds when end is disabled or u < E. With invert clear, an address inside both bounds bypasses, provided at least one of the two enables is set.
- R6: With the invert control (start register bit 30) set and at least one window enable set, an address that fails either bound bypasses instead. With the window set up as the start and end of a translated aperture, this sends every address below the aperture start through untranslated.
- R7: When `cfg_fine_unit` is 1, the window unit index u is address bits 35:22 (4 MB units). When it is 0, u is bits 35:28 (256 MB units). The cap always uses 256 MB units.
- R8: An enabled, non-faulting address that is not bypassed is routed as translate (route code 2'b01).
- R9: Control bit 27 is a sticky flag that is set in the cycle after any valid request is routed as fault. Writing 1 to it clears it, and writing 0 leaves it unchanged. A fault in the same cycle as a clearing write leaves the flag set.
- R10: When the abort enable (control bit 26) is set, `abort_o` is high in the same cycle as a valid request routed as fault, and low at all other times.
- R11: One cycle after a valid faulting request, `irq_o` pulses for one cycle if the interrupt enable (control bit 25) is set. `exc_o` pulses in the same way if the exception enable (control bit 24) is set.
- R12: The register select is 0 for control, 1 for cap, 2 for window start and 3 for window end. `reg_rdata` shows the selected register in the same cycle, with only the fields named above readable and every other bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fine_unit | input | 1 | 1 selects 4 MB window units, 0 selects 256 MB |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 36 | Device address to classify |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 cap, 2 start, 3 end |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| route_o | output | 2 | Route: 00 bypass, 01 translate, 10 fault |
| phys_o | output | 36 | Forwarded address for bypass, else 0 |
| abort_o | output | 1 | Same-cycle abort of a faulting request |
| irq_o | output | 1 | Interrupt pulse one cycle after a fault |
| exc_o | output | 1 | Exception pulse one cycle after a fault |

## Verification
The route, the forwarded address and the abort depend on the current request and the stored registers alone, so they are due in the cycle the request is presented. Register reads are due in the same cycle as the select. A written value, the sticky flag, and the interrupt and exception pulses take effect after the next rising edge. The bench changes every input on the falling edge. It checks same-cycle results 1 ns later, before the next rising edge, and checks registered results after one further falling edge. The route is swept across every coarse unit, and across a band of fine units around the aperture boundaries, for each register setup.

// File: rtl/irc_pkg.sv
package irc_pkg;

  typedef enum logic [1:0] {
    ROUTE_BYPASS = 2'b00,
    ROUTE_XLATE  = 2'b01,
    ROUTE_FAULT  = 2'b10
  } route_e;

  // register select codes
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_CAP   = 2'd1;
  localparam logic [1:0] SEL_START = 2'd2;
  localparam logic [1:0] SEL_END   = 2'd3;

  // control register bit positions
  localparam int CTL_FLAG  = 27;
  localparam int CTL_ABORT = 26;
  localparam int CTL_IRQ   = 25;
  localparam int CTL_EXC   = 24;
  localparam int CTL_GBYP  = 8;
  localparam int CTL_EN    = 0;

  // limit register bit positions
  localparam int LIM_EN    = 31;
  localparam int LIM_INV   = 30;

endpackage

// File: rtl/irc_cfg_regs.sv
module irc_cfg_regs
  import irc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CAP_W  = 8,
  parameter int WIN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic              gbyp,
  output logic              abort_en,
  output logic              irq_en,
  output logic              exc_en,
  output logic              cap_en,
  output logic [CAP_W-1:0]  cap_lim,
  output logic              st_en,
  output logic              st_inv,
  output logic [WIN_W-1:0]  st_lim,
  output logic              end_en,
  output logic [WIN_W-1:0]  end_lim
);

  logic wr_ctl, wr_cap, wr_st, wr_end;
  logic [4:0]       ctl_q, ctl_d;
  logic [CAP_W:0]   cap_q, cap_d;
  logic [WIN_W+1:0] st_q,  st_d;
  logic [WIN_W:0]   end_q, end_d;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;

  // write decode and next-state values
  always_comb begin
    wr_ctl = wr && (sel == SEL_CTRL);
    wr_cap = wr && (sel == SEL_CAP);
    wr_st  = wr && (sel == SEL_START);
    wr_end = wr && (sel == SEL_END);
    ctl_d  = {wdata[CTL_ABORT], wdata[CTL_IRQ], wdata[CTL_EXC],
              wdata[CTL_GBYP], wdata[CTL_EN]};
    cap_d  = {wdata[LIM_EN], wdata[CAP_W-1:0]};
    st_d   = {wdata[LIM_EN], wdata[LIM_INV], wdata[WIN_W-1:0]};
    end_d  = {wdata[LIM_EN], wdata[WIN_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cap_q <= '0;
      st_q  <= '0;
      end_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_d;
      if (wr_cap) cap_q <= cap_d;
      if (wr_st)  st_q  <= st_d;
      if (wr_end) end_q <= end_d;
    end
  end

  assign {abort_en, irq_en, exc_en, gbyp, en} = ctl_q;
  assign {cap_en, cap_lim}        = cap_q;
  assign {st_en, st_inv, st_lim}  = st_q;
  assign {end_en, end_lim}        = end_q;

endmodule

// File: rtl/irc_route.sv
module irc_route
  import irc_pkg::*;
#(
  parameter int CAP_W = 8,
  parameter int WIN_W = 14
) (
  input  logic [WIN_W-1:0] addr_hi,
  input  logic             fine,
  input  logic             en,
  input  logic             gbyp,
  input  logic             cap_en,
  input  logic [CAP_W-1:0] cap_lim,
  input  logic             st_en,
  input  logic             st_inv,
  input  logic [WIN_W-1:0] st_lim,
  input  logic             end_en,
  input  logic [WIN_W-1:0] end_lim,
  output route_e           route
);

  logic [CAP_W-1:0] coarse_idx;
  logic [WIN_W-1:0] unit;
  logic             over_cap, lo_ok, hi_ok, in_win, win_byp;

  always_comb begin
    coarse_idx = addr_hi[WIN_W-1 -: CAP_W];
    unit       = fine ? addr_hi : WIN_W'(coarse_idx);
    over_cap   = cap_en && (coarse_idx > cap_lim);
    // start is stored one below its boundary, end is the boundary itself
    lo_ok      = !st_en  || (unit > st_lim);
    hi_ok      = !end_en || (unit < end_lim);
    in_win     = lo_ok && hi_ok;
    win_byp    = (st_en || end_en) && (st_inv ? !in_win : in_win);

    if (!en || gbyp)  route = ROUTE_BYPASS;
    else if (over_cap) route = ROUTE_FAULT;
    else if (win_byp)  route = ROUTE_BYPASS;
    else               route = ROUTE_XLATE;
  end

endmodule

// File: rtl/irc_fault.sv
module irc_fault
  import irc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  route_e route,
  input  logic   clr,
  input  logic   abort_en,
  input  logic   irq_en,
  input  logic   exc_en,
  output logic   flag,
  output logic   abort_o,
  output logic   irq_o,
  output logic   exc_o
);

  logic hit;
  logic flag_d, irq_d, exc_d, flag_ce;

  always_comb begin
    hit     = req_valid && (route == ROUTE_FAULT);
    flag_ce = hit || clr;
    flag_d  = hit;           // a new fault wins over a clearing write
    irq_d   = hit && irq_en;
    exc_d   = hit && exc_en;
    abort_o = hit && abort_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      irq_o <= 1'b0;
      exc_o <= 1'b0;
    end else begin
      if (flag_ce) flag <= flag_d;
      irq_o <= irq_d;
      exc_o <= exc_d;
    end
  end

endmodule

// File: rtl/iommu_range_classifier.sv
module iommu_range_classifier
  import irc_pkg::*;
#(
  parameter int ADDR_W       = 36,
  parameter int COARSE_SHIFT = 28,
  parameter int FINE_SHIFT   = 22,
  parameter int DATA_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fine_unit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        route_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic              abort_o,
  output logic              irq_o,
  output logic              exc_o
);

  localparam int CAP_W = ADDR_W - COARSE_SHIFT;
  localparam int WIN_W = ADDR_W - FINE_SHIFT;

  logic             ctl_en, gbyp, abort_en, irq_en, exc_en;
  logic             cap_en, st_en, st_inv, end_en;
  logic [CAP_W-1:0] cap_lim;
  logic [WIN_W-1:0] st_lim, end_lim;
  logic             cap_flag, flag_clr;
  route_e           route;

  irc_cfg_regs #(.DATA_W(DATA_W), .CAP_W(CAP_W), .WIN_W(WIN_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .en       (ctl_en),
    .gbyp     (gbyp),
    .abort_en (abort_en),
    .irq_en   (irq_en),
    .exc_en   (exc_en),
    .cap_en   (cap_en),
    .cap_lim  (cap_lim),
    .st_en    (st_en),
    .st_inv   (st_inv),
    .st_lim   (st_lim),
    .end_en   (end_en),
    .end_lim  (end_lim)
  );

  irc_route #(.CAP_W(CAP_W), .WIN_W(WIN_W)) u_route (
    .addr_hi (req_addr[ADDR_W-1:FINE_SHIFT]),
    .fine    (cfg_fine_unit),
    .en      (ctl_en),
    .gbyp    (gbyp),
    .cap_en  (cap_en),
    .cap_lim (cap_lim),
    .st_en   (st_en),
    .st_inv  (st_inv),
    .st_lim  (st_lim),
    .end_en  (end_en),
    .end_lim (end_lim),
    .route   (route)
  );

  assign flag_clr = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CTL_FLAG];

  irc_fault u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .route     (route),
    .clr       (flag_clr),
    .abort_en  (abort_en),
    .irq_en    (irq_en),
    .exc_en    (exc_en),
    .flag      (cap_flag),
    .abort_o   (abort_o),
    .irq_o     (irq_o),
    .exc_o     (exc_o)
  );

  assign route_o = route;
  assign phys_o  = (route == ROUTE_BYPASS) ? req_addr : '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[CTL_FLAG]  = cap_flag;
        reg_rdata[CTL_ABORT] = abort_en;
        reg_rdata[CTL_IRQ]   = irq_en;
        reg_rdata[CTL_EXC]   = exc_en;
        reg_rdata[CTL_GBYP]  = gbyp;
        reg_rdata[CTL_EN]    = ctl_en;
      end
      SEL_CAP: begin
        reg_rdata[LIM_EN]      = cap_en;
        reg_rdata[CAP_W-1:0]   = cap_lim;
      end
      SEL_START: begin
        reg_rdata[LIM_EN]      = st_en;
        reg_rdata[LIM_INV]     = st_inv;
        reg_rdata[WIN_W-1:0]   = st_lim;
      end
      default: begin
        reg_rdata[LIM_EN]      = end_en;
        reg_rdata[WIN_W-1:0]   = end_lim;
      end
    endcase
  end

endmodule

module irc_checker
  import irc_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        route_o,
  input logic [ADDR_W-1:0] phys_o,
  input logic              abort_o,
  input logic              irq_o,
  input logic              exc_o,
  input logic              cap_flag,
  input logic              ctl_en,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata
);

  a_r2_disabled_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (route_o == ROUTE_BYPASS) && !abort_o);

  a_r2_phys_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && route_o == ROUTE_BYPASS) |-> phys_o == req_addr);

  a_r4_route_legal: assert property (@(posedge clk) disable iff (!rst_n)
    route_o != 2'b11);

  a_r10_abort_only_fault: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (req_valid && route_o == ROUTE_FAULT));

  a_r11_irq_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(req_valid && route_o == ROUTE_FAULT));

  a_r11_exc_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> $past(req_valid && route_o == ROUTE_FAULT));

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && route_o == ROUTE_FAULT) |=> cap_flag);

  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && route_o == ROUTE_FAULT) &&
     !(reg_wr && reg_sel == SEL_CTRL && reg_wdata[CTL_FLAG])) |=> $stable(cap_flag));

endmodule

bind iommu_range_classifier irc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .route_o   (route_o),
  .phys_o    (phys_o),
  .abort_o   (abort_o),
  .irq_o     (irq_o),
  .exc_o     (exc_o),
  .cap_flag  (cap_flag),
  .ctl_en    (ctl_en),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata)
);

// File: tb/iommu_range_classifier_test.sv
module iommu_range_classifier_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_fine_unit;
  logic        req_valid;
  logic [35:0] req_addr;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  route_o;
  logic [35:0] phys_o;
  logic        abort_o, irq_o, exc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench copy of programmed fields
  logic        m_en, m_gbyp, m_abort, m_irq, m_exc;
  logic        m_cap_en, m_st_en, m_inv, m_end_en;
  logic [7:0]  m_cap;
  logic [13:0] m_st, m_end;

  always #2 clk = ~clk;   // 250 MHz

  iommu_range_classifier uut (
    .clk(clk), .rst_n(rst_n), .cfg_fine_unit(cfg_fine_unit),
    .req_valid(req_valid), .req_addr(req_addr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .route_o(route_o), .phys_o(phys_o),
    .abort_o(abort_o), .irq_o(irq_o), .exc_o(exc_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [35:0] a);
    logic [7:0]  cu;
    logic [13:0] u;
    logic        lo, hi, inw;
    cu = a[35:28];
    u  = cfg_fine_unit ? a[35:22] : {6'b0, cu};
    if (!m_en || m_gbyp) return 2'b00;
    if (m_cap_en && cu > m_cap) return 2'b10;
    lo  = !m_st_en || (u > m_st);
    hi  = !m_end_en || (u < m_end);
    inw = lo && hi;
    if ((m_st_en || m_end_en) && (m_inv ? !inw : inw)) return 2'b00;
    return 2'b01;
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (sel)
      2'd0: begin m_en = d[0]; m_gbyp = d[8]; m_abort = d[26];
                  m_irq = d[25]; m_exc = d[24]; end
      2'd1: begin m_cap_en = d[31]; m_cap = d[7:0]; end
      2'd2: begin m_st_en = d[31]; m_inv = d[30]; m_st = d[13:0]; end
      default: begin m_end_en = d[31]; m_end = d[13:0]; end
    endcase
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [31:0] exp,
                          input string tag);
    @(negedge clk);
    reg_sel = sel;
    #1;
    check(reg_rdata === exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  // same-cycle route, forwarded address and abort
  task automatic probe(input logic [35:0] a, input string tag);
    logic [1:0]  er;
    logic [38:0] act, exp;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1;
    er  = model(a);
    exp = {er, (er == 2'b00) ? a : 36'd0, (er == 2'b10) && m_abort};
    act = {route_o, phys_o, abort_o};
    check(act === exp, tag, 64'(act), 64'(exp));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sweep_coarse(input string tag);
    for (int u = 0; u < 256; u++)
      probe({8'(u), 28'(u * 32'h0123457)}, tag);
    idle();
  endtask

  task automatic sweep_fine(input int lo, input int hi, input string tag);
    for (int u = lo; u <= hi; u++)
      probe({14'(u), 22'(u * 32'h00ABCDE)}, tag);
    idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_fine_unit = 1'b0; req_valid = 1'b0; req_addr = '0;
    reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    {m_en, m_gbyp, m_abort, m_irq, m_exc} = '0;
    {m_cap_en, m_st_en, m_inv, m_end_en} = '0;
    m_cap = '0; m_st = '0; m_end = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 4; s++) rd_check(2'(s), 32'h0, "R1 reset register");
    probe(36'hA_1234_5678, "R1 reset route bypass");
    idle();

    // R2: disabled unit ignores a tight cap
    wr_reg(2'd1, 32'h8000_0000);
    wr_reg(2'd0, 32'h0400_0000);
    sweep_coarse("R2 disabled bypass");
    rd_check(2'd0, 32'h0400_0000, "R2 no flag while disabled");

    // R4 R8 R10: cap limit 10 inclusive, abort on
    wr_reg(2'd1, 32'h8000_000A);
    wr_reg(2'd0, 32'h0400_0001);
    sweep_coarse("R4 R8 R10 cap sweep");
    probe({8'd10, 28'hFFF_FFFF}, "R4 top of limit unit legal");
    probe({8'd11, 28'h000_0000}, "R4 first unit above limit faults");
    idle();

    // R3: global bypass overrides cap
    wr_reg(2'd0, 32'h0400_0101);
    sweep_coarse("R3 global bypass");

    // R5: plain window 4..6, cap off
    wr_reg(2'd0, 32'h0400_0001);
    wr_reg(2'd1, 32'h0000_0000);
    wr_reg(2'd2, 32'h8000_0003);
    wr_reg(2'd3, 32'h8000_0007);
    sweep_coarse("R5 window");
    wr_reg(2'd3, 32'h0000_0007);
    sweep_coarse("R5 start only");

    // R6: inverted window as an aperture 160..167 with cap 167
    wr_reg(2'd1, 32'h8000_00A7);
    wr_reg(2'd2, 32'hC000_009F);
    wr_reg(2'd3, 32'h8000_00A8);
    sweep_coarse("R6 invert coarse");

    // R7: fine units, aperture 10240..10751
    wr_reg(2'd2, 32'hC000_27FF);
    wr_reg(2'd3, 32'h8000_2A00);
    cfg_fine_unit = 1'b1;
    sweep_fine(10200, 10800, "R7 fine units");
    sweep_coarse("R7 fine coarse sweep");
    cfg_fine_unit = 1'b0;
    sweep_coarse("R7 coarse with fine limits");

    // R9: sticky flag behaviour
    rd_check(2'd0, 32'h0C00_0001, "R9 flag set by fault");
    wr_reg(2'd0, 32'h0400_0001);
    rd_check(2'd0, 32'h0C00_0001, "R9 write 0 keeps flag");
    wr_reg(2'd0, 32'h0C00_0001);
    rd_check(2'd0, 32'h0400_0001, "R9 write 1 clears flag");
    @(negedge clk);
    req_valid = 1'b1; req_addr = {8'd200, 28'd5};
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0800_0001;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    m_abort = 1'b0;
    rd_check(2'd0, 32'h0800_0001, "R9 fault wins over clear");

    // R11: interrupt pulse only
    wr_reg(2'd0, 32'h0A00_0001);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {8'd200, 28'd7};
    #1;
    check(abort_o === 1'b0, "R10 no abort when disabled", 64'(abort_o), 64'd0);
    check({irq_o, exc_o} === 2'b00, "R11 no pulse in fault cycle", 64'({irq_o, exc_o}), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check({irq_o, exc_o} === 2'b10, "R11 irq pulse", 64'({irq_o, exc_o}), 64'h2);
    @(negedge clk); #1;
    check({irq_o, exc_o} === 2'b00, "R11 irq one cycle", 64'({irq_o, exc_o}), 64'd0);

    // R11: exception pulse only
    wr_reg(2'd0, 32'h0900_0001);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {8'd210, 28'd9};
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check({irq_o, exc_o} === 2'b01, "R11 exc pulse", 64'({irq_o, exc_o}), 64'h1);
    @(negedge clk); #1;
    check({irq_o, exc_o} === 2'b00, "R11 exc one cycle", 64'({irq_o, exc_o}), 64'd0);

    // R12: readable field masks
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_check(2'd0, 32'h0700_0101, "R12 ctrl mask");
    for (int s = 1; s < 4; s++) wr_reg(2'(s), 32'hFFFF_FFFF);
    rd_check(2'd1, 32'h8000_00FF, "R12 cap mask");
    rd_check(2'd2, 32'hC000_3FFF, "R12 start mask");
    rd_check(2'd3, 32'h8000_3FFF, "R12 end mask");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule